// File: doc/BRIEF.md
# Interrupt Group with Atomic Set/Clear Mask

This block gathers up to one bus word of event lines into a single interrupt request. Each event line feeds its own pending flag. A flag is set whenever its line is high at a clock edge, and it stays set until software clears it. Software can also inject events for test. All pending flags share one interrupt output, gated by a mask.

The mask is never written as a whole word. One address sets mask bits and a second address clears them, and only the bits written as 1 change. Several processor cores can therefore each flip their own mask bit without a read-modify-write race. A masked status view shows which pending flags currently request an interrupt.

The register port is a simple select/enable/write bus that is always ready. Reads return data in the same access cycle, and writes take effect at the clock edge that ends the access.

Top module: `irq_atomic_group`

## Requirements
- R1: After reset every pending flag is 0, every mask bit is 1, status reads 0 and the interrupt output is 0.
- R2: An event line that is high at a clock edge sets its pending flag at that edge. The flag stays set after the line falls.
- R3: Writing to the pending register (offset 0x00) clears each flag whose data bit is 1 and leaves the other flags alone. If a clear and an event hit the same bit in the same cycle, the flag stays set.
- R4: Writing a 1 to a bit of the force register (offset 0x04) sets the matching pending flag at that edge, the same way an event does. The force register always reads 0.
- R5: A write to the mask-set address (0x08) sets only the mask bits written as 1. A write to the mask-clear address (0x0C) clears only the mask bits written as 1. Reading either address returns the current mask.
- R6: The status register (0x10) reads pending AND NOT mask, so a mask bit of 1 blocks its source. Writes to status change nothing.
- R7: The interrupt output is registered and equals the OR of the status bits. It rises at the edge that makes a status bit 1. It falls at the edge where the last status bit is cleared or masked.
- R8: Data bits at positions NUM_EVT and above read 0, and writes to them have no effect. Addresses outside the five word-aligned offsets above the base read 0 and change nothing when written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_i | input | NUM_EVT | Event lines, one per pending flag |
| bus_sel | input | 1 | Register access select |
| bus_en | input | 1 | Access phase enable |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid during the access |
| bus_ready | output | 1 | Always 1, no wait states |
| irq_o | output | 1 | Merged interrupt request |

## Verification
The bench builds the block with NUM_EVT = 6 on a 32-bit data bus and a non-zero base address of 0x1000. The narrow event count puts the ignored upper data bits within reach: a mask-set write with only those bits set must leave the mask as it was. The non-zero base lets the bench confirm that decoding is relative to the base and that an offset past the last register decodes to nothing. With only six flags, the bench can follow each pending and mask bit by hand through collisions such as a clear meeting an event, and a mask-set meeting an event, in the same cycle.

// File: rtl/irqgrp_pkg.sv
package irqgrp_pkg;

  // Word offsets of the registers relative to the base address
  localparam logic [4:0] OFS_PEND  = 5'h00;
  localparam logic [4:0] OFS_FORCE = 5'h04;
  localparam logic [4:0] OFS_MSET  = 5'h08;
  localparam logic [4:0] OFS_MCLR  = 5'h0C;
  localparam logic [4:0] OFS_STAT  = 5'h10;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_PEND,
    SEL_FORCE,
    SEL_MSET,
    SEL_MCLR,
    SEL_STAT
  } reg_sel_e;

  function automatic reg_sel_e sel_of_offset(input logic [4:0] ofs);
    case (ofs)
      OFS_PEND:  return SEL_PEND;
      OFS_FORCE: return SEL_FORCE;
      OFS_MSET:  return SEL_MSET;
      OFS_MCLR:  return SEL_MCLR;
      OFS_STAT:  return SEL_STAT;
      default:   return SEL_NONE;
    endcase
  endfunction

endpackage

// File: rtl/irqgrp_decode.sv
module irqgrp_decode
  import irqgrp_pkg::*;
#(
  parameter int unsigned          ADDR_W    = 32,
  parameter logic [ADDR_W-1:0]    BASE_ADDR = '0
) (
  input  logic              bus_sel,
  input  logic              bus_en,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  output reg_sel_e          rd_sel,
  output logic              we_pend,
  output logic              we_force,
  output logic              we_mset,
  output logic              we_mclr
);

  logic [ADDR_W-1:0] rel;
  logic              in_window;
  reg_sel_e          hit;
  logic              wr_access;

  assign rel       = bus_addr - BASE_ADDR;
  assign in_window = (rel[ADDR_W-1:5] == '0);
  assign hit       = in_window ? sel_of_offset(rel[4:0]) : SEL_NONE;
  assign wr_access = bus_sel & bus_en & bus_write;

  assign we_pend  = wr_access && (hit == SEL_PEND);
  assign we_force = wr_access && (hit == SEL_FORCE);
  assign we_mset  = wr_access && (hit == SEL_MSET);
  assign we_mclr  = wr_access && (hit == SEL_MCLR);
  assign rd_sel   = (bus_sel && !bus_write) ? hit : SEL_NONE;

  // R8: at most one register may take a write in any access
  always_comb begin
    assert_one_strobe_R8: assert ($onehot0({we_pend, we_force, we_mset, we_mclr}));
  end

endmodule

// File: rtl/irqgrp_pending.sv
module irqgrp_pending #(
  parameter int unsigned NUM_EVT = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic [NUM_EVT-1:0] wbits_i,
  input  logic               we_pend,
  input  logic               we_force,
  input  logic               we_mset,
  input  logic               we_mclr,
  output logic [NUM_EVT-1:0] pend_o,
  output logic [NUM_EVT-1:0] mask_o,
  output logic [NUM_EVT-1:0] status_o,
  output logic [NUM_EVT-1:0] status_next_o
);

  typedef logic [NUM_EVT-1:0] vec_t;

  // Pending update: clear first, then any event or force sets the bit again
  function automatic vec_t pend_update(input vec_t cur, input vec_t evt,
                                       input vec_t frc, input vec_t clr);
    return (cur & ~clr) | evt | frc;
  endfunction

  // Mask update: only bits written as 1 move
  function automatic vec_t mask_update(input vec_t cur, input vec_t setb,
                                       input vec_t clrb);
    return (cur | setb) & ~clrb;
  endfunction

  vec_t pend_q, mask_q, pend_d, mask_d;

  assign pend_d = pend_update(pend_q, evt_i,
                              we_force ? wbits_i : '0,
                              we_pend  ? wbits_i : '0);
  assign mask_d = mask_update(mask_q,
                              we_mset ? wbits_i : '0,
                              we_mclr ? wbits_i : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      mask_q <= '1;
    end else begin
      pend_q <= pend_d;
      mask_q <= mask_d;
    end
  end

  assign pend_o        = pend_q;
  assign mask_o        = mask_q;
  assign status_o      = pend_q & ~mask_q;
  assign status_next_o = pend_d & ~mask_d;

  assert_evt_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i != '0) |=> ((pend_q & $past(evt_i)) == $past(evt_i)));

  assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    we_pend |=> ((pend_q & $past(wbits_i & ~evt_i)) == '0));

  assert_force_R4: assert property (@(posedge clk) disable iff (!rst_n)
    we_force |=> ((pend_q & $past(wbits_i)) == $past(wbits_i)));

  assert_mask_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    we_mset |=> (((mask_q & $past(wbits_i)) == $past(wbits_i)) &&
                 ((mask_q & ~$past(wbits_i)) == ($past(mask_q) & ~$past(wbits_i)))));

  assert_mask_clr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    we_mclr |=> (((mask_q & $past(wbits_i)) == '0) &&
                 ((mask_q & ~$past(wbits_i)) == ($past(mask_q) & ~$past(wbits_i)))));

  assert_mask_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(we_mset || we_mclr) |=> $stable(mask_q));

  assert_pend_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt_i == '0) && !we_pend && !we_force) |=> $stable(pend_q));

endmodule

// File: rtl/irqgrp_merge.sv
module irqgrp_merge #(
  parameter int unsigned NUM_EVT = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] status_next_i,
  input  logic [NUM_EVT-1:0] status_i,
  output logic               irq_o
);

  logic irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |status_next_i;
  end

  assign irq_o = irq_q;

  // R7: the registered request always agrees with the live status view
  assert_irq_tracks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == (|status_i));

endmodule

// File: rtl/irq_atomic_group.sv
module irq_atomic_group
  import irqgrp_pkg::*;
#(
  parameter int unsigned       DATA_W    = 32,
  parameter int unsigned       NUM_EVT   = 16,
  parameter int unsigned       ADDR_W    = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic               bus_sel,
  input  logic               bus_en,
  input  logic               bus_write,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  output logic               bus_ready,
  output logic               irq_o
);

  if ((NUM_EVT < 1) || (NUM_EVT > DATA_W)) begin : g_bad_cfg
    $error("irq_atomic_group: NUM_EVT must lie between 1 and DATA_W");
  end

  if (NUM_EVT < DATA_W) begin : g_hi_bits
    logic unused_hi;
    assign unused_hi = |bus_wdata[DATA_W-1:NUM_EVT];
  end

  reg_sel_e           rd_sel;
  logic               we_pend, we_force, we_mset, we_mclr;
  logic [NUM_EVT-1:0] wbits, pend, mask, status, status_next;

  assign wbits = bus_wdata[NUM_EVT-1:0];

  irqgrp_decode #(
    .ADDR_W    (ADDR_W),
    .BASE_ADDR (BASE_ADDR)
  ) u_decode (
    .bus_sel   (bus_sel),
    .bus_en    (bus_en),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .rd_sel    (rd_sel),
    .we_pend   (we_pend),
    .we_force  (we_force),
    .we_mset   (we_mset),
    .we_mclr   (we_mclr)
  );

  irqgrp_pending #(
    .NUM_EVT (NUM_EVT)
  ) u_pending (
    .clk           (clk),
    .rst_n         (rst_n),
    .evt_i         (evt_i),
    .wbits_i       (wbits),
    .we_pend       (we_pend),
    .we_force      (we_force),
    .we_mset       (we_mset),
    .we_mclr       (we_mclr),
    .pend_o        (pend),
    .mask_o        (mask),
    .status_o      (status),
    .status_next_o (status_next)
  );

  irqgrp_merge #(
    .NUM_EVT (NUM_EVT)
  ) u_merge (
    .clk           (clk),
    .rst_n         (rst_n),
    .status_next_i (status_next),
    .status_i      (status),
    .irq_o         (irq_o)
  );

  always_comb begin
    case (rd_sel)
      SEL_PEND:          bus_rdata = DATA_W'(pend);
      SEL_MSET, SEL_MCLR: bus_rdata = DATA_W'(mask);
      SEL_STAT:          bus_rdata = DATA_W'(status);
      default:           bus_rdata = '0;
    endcase
  end

  assign bus_ready = 1'b1;

  // R4: the force register never returns data
  always_comb begin
    if (rd_sel == SEL_FORCE) begin
      assert_force_reads_zero_R4: assert (bus_rdata == '0);
    end
  end

endmodule

// File: tb/sim_irq_atomic_group.sv
module sim_irq_atomic_group;

  localparam int          DW   = 32;
  localparam int          NE   = 6;
  localparam int          AW   = 32;
  localparam logic [31:0] BASE = 32'h0000_1000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NE-1:0] evt = '0;
  logic          sel = 1'b0, en = 1'b0, wr = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          ready, irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  irq_atomic_group #(
    .DATA_W (DW), .NUM_EVT (NE), .ADDR_W (AW), .BASE_ADDR (BASE)
  ) u0 (
    .clk (clk), .rst_n (rst_n), .evt_i (evt),
    .bus_sel (sel), .bus_en (en), .bus_write (wr),
    .bus_addr (addr), .bus_wdata (wdata), .bus_rdata (rdata),
    .bus_ready (ready), .irq_o (irq)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // One clock: events and an optional write share the same edge
  task automatic step(input logic [NE-1:0] e, input logic w,
                      input logic [7:0] ofs, input logic [31:0] d);
    @(negedge clk);
    evt = e; sel = w; en = w; wr = w; addr = BASE + 32'(ofs); wdata = d;
    @(posedge clk);
    @(negedge clk);
    evt = '0; sel = 1'b0; en = 1'b0; wr = 1'b0; wdata = '0;
  endtask

  // Reads are combinational: no clock edge is crossed
  task automatic rd(input logic [31:0] a, output logic [31:0] v);
    @(negedge clk);
    sel = 1'b1; en = 1'b1; wr = 1'b0; addr = a;
    #2;
    v = rdata;
    sel = 1'b0; en = 1'b0;
  endtask

  task automatic check_state(input string tag, input logic [NE-1:0] ep,
                             input logic [NE-1:0] em);
    logic [31:0] v;
    rd(BASE + 32'h00, v); check({tag, " R2 R3 R4"}, "pending", v, 32'(ep));
    rd(BASE + 32'h08, v); check({tag, " R5"}, "mask@set", v, 32'(em));
    rd(BASE + 32'h0C, v); check({tag, " R5"}, "mask@clr", v, 32'(em));
    rd(BASE + 32'h10, v); check({tag, " R6"}, "status", v, 32'(ep & ~em));
    rd(BASE + 32'h04, v); check({tag, " R4"}, "force", v, 32'h0);
  endtask

  typedef struct packed {
    logic [5:0]  evt;
    logic        w;
    logic [7:0]  ofs;
    logic [31:0] wd;
    logic [5:0]  pend;
    logic [5:0]  msk;
    logic        irq;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{6'h05, 1'b0, 8'h00, 32'h0000_0000, 6'h05, 6'h3F, 1'b0}, // R2 events while masked
    '{6'h00, 1'b1, 8'h0C, 32'h0000_0001, 6'h05, 6'h3E, 1'b1}, // R5 open bit0
    '{6'h00, 1'b1, 8'h00, 32'h0000_0001, 6'h04, 6'h3E, 1'b0}, // R3 clear bit0
    '{6'h00, 1'b1, 8'h08, 32'hFFFF_FFC0, 6'h04, 6'h3E, 1'b0}, // R8 upper bits only
    '{6'h00, 1'b1, 8'h0C, 32'h0000_0024, 6'h04, 6'h1A, 1'b1}, // R5 open bits 2,5
    '{6'h00, 1'b1, 8'h04, 32'h0000_0008, 6'h0C, 6'h1A, 1'b1}, // R4 force bit3
    '{6'h04, 1'b1, 8'h00, 32'h0000_0004, 6'h0C, 6'h1A, 1'b1}, // R3 event beats clear
    '{6'h00, 1'b1, 8'h00, 32'h0000_000C, 6'h00, 6'h1A, 1'b0}, // R7 fall on clear
    '{6'h00, 1'b1, 8'h10, 32'h0000_003F, 6'h00, 6'h1A, 1'b0}, // R6 status write ignored
    '{6'h20, 1'b1, 8'h08, 32'h0000_0020, 6'h20, 6'h3A, 1'b0}, // R5 mask and event together
    '{6'h00, 1'b1, 8'h0C, 32'h0000_0020, 6'h20, 6'h1A, 1'b1}, // R7 rise on unmask
    '{6'h00, 1'b1, 8'h08, 32'h0000_003F, 6'h20, 6'h3F, 1'b0}  // R7 fall on mask
  };

  initial begin
    logic [31:0] v;
    // Reset state
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    check("R1", "irq after reset", 32'(irq), 32'h0);
    check("R1", "ready", 32'(ready), 32'h1);
    check_state("R1", 6'h00, 6'h3F);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      step(VEC[i].evt, VEC[i].w, VEC[i].ofs, VEC[i].wd);
      check("R7", $sformatf("irq vec %0d", i), 32'(irq), 32'(VEC[i].irq));
      check_state($sformatf("vec%0d", i), VEC[i].pend, VEC[i].msk);
    end

    // R8: unmapped and misaligned addresses
    rd(BASE + 32'h14, v); check("R8", "unmapped read", v, 32'h0);
    rd(BASE + 32'h02, v); check("R8", "misaligned read", v, 32'h0);
    rd(32'h0000_0008, v); check("R8", "below-base read", v, 32'h0);
    step(6'h00, 1'b1, 8'h14, 32'h0000_003F);
    check_state("R8", 6'h20, 6'h3F);

    // R7 edge timing with an open mask
    step(6'h00, 1'b1, 8'h0C, 32'h0000_003F);
    check("R7", "rise on mask clear", 32'(irq), 32'h1);
    step(6'h00, 1'b1, 8'h00, 32'h0000_0020);
    check("R7", "fall on pending clear", 32'(irq), 32'h0);
    @(negedge clk); evt = 6'h02;
    #1 check("R7", "no rise before edge", 32'(irq), 32'h0);
    @(posedge clk); @(negedge clk); evt = '0;
    check("R7", "rise after edge", 32'(irq), 32'h1);
    check_state("R2", 6'h02, 6'h00);

    // R1 reset in the middle of activity
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    check("R1", "irq after mid reset", 32'(irq), 32'h0);
    check_state("R1", 6'h00, 6'h3F);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule